// File: doc/BRIEF.md
# SPI Burst Read Engine

This engine pulls a block of bytes out of a remote SPI device inside one chip-select frame. A request carries a 16-bit byte count N. Once the request is taken, the engine opens the frame. It writes the count, minus one, into the remote device's two length registers, then shifts one throw-away byte. After that it clocks in the N payload bytes while holding its own output line low.

Each payload byte is handed to the surrounding logic as a one-cycle strobe with the byte value. The strobe for the final byte also carries an end marker. When the last byte has arrived, the engine closes the frame, pulses a completion strobe and returns to idle. The SPI clock runs at half the system clock. Data leaves most significant bit first, and input bits are captured on the clock edge that drives the serial clock from high to low.

Top module: `spi_burst_reader`

## Requirements
- R1: After reset, and whenever no frame is open, `sck` is 0, `cs_n` is 1 and `mosi` is 0. After reset `busy`, `done` and `rx_valid` are 0.
- R2: A request taken while idle with N ≠ 0 drops `cs_n` in the next cycle. In that same cycle `mosi` already carries bit 7 of the first setup byte, with `sck` low and no setup wait.
- R3: While `cs_n` is low, `sck` starts low and inverts on every clock, so each bit lasts two clocks. A frame has exactly 8·(N+5) rising edges of `sck`.
- R4: The first four bytes on `mosi` are 0x8C, (N−1)[7:0], 0x8D and (N−1)[15:8], in that order. Each is sent MSB first and sampled by the remote device on the rising edge of `sck`.
- R5: The fifth byte on `mosi` is 0x00. Whatever `miso` carries during it never reaches `rx_valid`, so exactly N bytes are delivered.
- R6: During the N payload bytes `mosi` stays 0. Each delivered byte is built MSB first from `miso`, taken at the clock edge where `sck` goes from 1 to 0.
- R7: Each payload byte raises `rx_valid` for exactly one clock with `rx_data`. `rx_last` is 1 only with the Nth byte.
- R8: The edge that completes the Nth byte raises `cs_n`, forces `sck` low and pulses `done` for one clock. `cs_n` is low for exactly 16·(N+5) clocks.
- R9: A request with N = 0 pulses `done` in the next cycle. It causes no `cs_n`, `sck` or `rx_valid` activity, and `busy` stays 0.
- R10: A request presented while `busy` is 1 is ignored. The frame in progress keeps its bytes and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_len | input | 16 | Number of bytes N to fetch |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion strobe |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the remote device |
| miso | input | 1 | Serial data from the remote device |
| rx_valid | output | 1 | Received payload byte strobe |
| rx_data | output | 8 | Received payload byte |
| rx_last | output | 1 | Marks the Nth payload byte |

## Verification
The hardest cases to reach are the length bytes whose two halves differ in non-trivial ways, such as N = 256 and N = 257, and a new request that arrives in the middle of a frame. The bench sweeps N over 0 through 3, both sides of the byte boundary at 256, and a few larger values. A model of the remote device returns a different computed byte pattern at every frame position, so a shifted or miscounted flush byte shows up as a data mismatch. One run sends a conflicting request while the frame is mid-stream, and the bench then checks that the length bytes and the byte count still match the original request.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int BYTE_W      = 8;
    localparam int LEN_W       = 2 * BYTE_W;
    localparam int SETUP_BYTES = 4;
    localparam int SIDX_W      = $clog2(SETUP_BYTES);

    localparam logic [BYTE_W-1:0] LEN_LO_CMD = 8'h8C;
    localparam logic [BYTE_W-1:0] LEN_HI_CMD = 8'h8D;
    localparam logic [BYTE_W-1:0] FLUSH_VAL  = 8'h00;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_FLUSH,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              last;
    } rx_beat_t;

    // Byte sent at a given position of the length-programming preamble.
    function automatic logic [BYTE_W-1:0] setup_byte(
        input logic [SIDX_W-1:0] idx,
        input logic [LEN_W-1:0]  len_m1
    );
        case (idx)
            2'd0:    setup_byte = LEN_LO_CMD;
            2'd1:    setup_byte = len_m1[BYTE_W-1:0];
            2'd2:    setup_byte = LEN_HI_CMD;
            default: setup_byte = len_m1[LEN_W-1:BYTE_W];
        endcase
    endfunction

endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int W = spi_burst_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] start_byte,
    input  logic         nxt_more,
    input  logic [W-1:0] nxt_byte,
    input  logic         miso,
    output logic         sck,
    output logic         cs_n,
    output logic         mosi,
    output logic         byte_end,
    output logic [W-1:0] rx_word
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic          active_q;
    logic          sck_q;
    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic [CW-1:0] bit_q;

    assign byte_end = active_q && sck_q && (bit_q == LAST_BIT);
    assign rx_word  = {rx_q[W-2:0], miso};
    assign sck      = sck_q;
    assign cs_n     = ~active_q;
    assign mosi     = active_q & tx_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_q    <= '0;
        end else if (!active_q) begin
            sck_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                tx_q     <= start_byte;
                rx_q     <= '0;
                bit_q    <= '0;
            end
        end else if (!sck_q) begin
            sck_q <= 1'b1;
        end else begin
            sck_q <= 1'b0;
            rx_q  <= rx_word;
            if (byte_end) begin
                bit_q <= '0;
                if (nxt_more) begin
                    tx_q <= nxt_byte;
                end else begin
                    active_q <= 1'b0;
                    tx_q     <= '0;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
                tx_q  <= {tx_q[W-2:0], 1'b0};
            end
        end
    end

    // R3
    sck_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> (sck_q != $past(sck_q)));

    // R1
    idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !sck_q);

    // R6
    mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q) && sck_q) |-> $stable(mosi));

endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              byte_end,
    input  logic [BYTE_W-1:0] rx_word,
    output logic              start,
    output logic [BYTE_W-1:0] start_byte,
    output logic              nxt_more,
    output logic [BYTE_W-1:0] nxt_byte,
    output logic              busy,
    output logic              done,
    output rx_beat_t          beat
);
    localparam logic [SIDX_W-1:0] LAST_SETUP = SIDX_W'(SETUP_BYTES - 1);

    phase_e             phase_q;
    logic [SIDX_W-1:0]  sidx_q;
    logic [LEN_W-1:0]   len_m1_q;
    logic [LEN_W-1:0]   remain_q;
    logic               done_q;
    rx_beat_t           beat_q;

    assign busy       = (phase_q != PH_IDLE);
    assign start      = (phase_q == PH_IDLE) && req_valid && (req_len != '0);
    assign start_byte = setup_byte('0, req_len - 1'b1);
    assign done       = done_q;
    assign beat       = beat_q;

    always_comb begin
        nxt_more = 1'b0;
        nxt_byte = FLUSH_VAL;
        case (phase_q)
            PH_SETUP: begin
                nxt_more = 1'b1;
                if (sidx_q != LAST_SETUP)
                    nxt_byte = setup_byte(sidx_q + 1'b1, len_m1_q);
            end
            PH_FLUSH: nxt_more = 1'b1;
            PH_DATA:  nxt_more = (remain_q != LEN_W'(1));
            default:  nxt_more = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            sidx_q   <= '0;
            len_m1_q <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
            beat_q   <= '0;
        end else begin
            done_q       <= 1'b0;
            beat_q.valid <= 1'b0;
            beat_q.last  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q  <= PH_SETUP;
                            sidx_q   <= '0;
                            len_m1_q <= req_len - 1'b1;
                            remain_q <= req_len;
                        end
                    end
                end
                PH_SETUP: begin
                    if (byte_end) begin
                        if (sidx_q == LAST_SETUP) phase_q <= PH_FLUSH;
                        sidx_q <= sidx_q + 1'b1;
                    end
                end
                PH_FLUSH: begin
                    if (byte_end) phase_q <= PH_DATA;
                end
                default: begin
                    if (byte_end) begin
                        beat_q.valid <= 1'b1;
                        beat_q.data  <= rx_word;
                        beat_q.last  <= (remain_q == LEN_W'(1));
                        remain_q     <= remain_q - 1'b1;
                        if (remain_q == LEN_W'(1)) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        beat_q.valid |=> !beat_q.valid);

    // R8
    last_done_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_q.valid && beat_q.last) |-> done_q);

    // R10
    hold_len_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(len_m1_q));

endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_last
);
    logic              start;
    logic [BYTE_W-1:0] start_byte;
    logic              nxt_more;
    logic [BYTE_W-1:0] nxt_byte;
    logic              byte_end;
    logic [BYTE_W-1:0] rx_word;
    rx_beat_t          beat;

    burst_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_len    (req_len),
        .byte_end   (byte_end),
        .rx_word    (rx_word),
        .start      (start),
        .start_byte (start_byte),
        .nxt_more   (nxt_more),
        .nxt_byte   (nxt_byte),
        .busy       (busy),
        .done       (done),
        .beat       (beat)
    );

    spi_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_byte (start_byte),
        .nxt_more   (nxt_more),
        .nxt_byte   (nxt_byte),
        .miso       (miso),
        .sck        (sck),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .byte_end   (byte_end),
        .rx_word    (rx_word)
    );

    assign rx_valid = beat.valid;
    assign rx_data  = beat.data;
    assign rx_last  = beat.last;

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sck && !mosi));

    // R5
    rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(!cs_n));

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !rx_valid) |-> cs_n);

endmodule

// File: tb/tb_spi_burst_reader.sv
`timescale 1ns/1ps
module tb_spi_burst_reader;
    localparam int MAXB = 320;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_len = '0;
    logic        busy, done, sck, cs_n, mosi, rx_valid, rx_last;
    logic [7:0]  rx_data;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    spi_burst_reader dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
        .busy(busy), .done(done), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    always #2 clk = ~clk;

    // monitor / remote device model state
    logic       clr = 1'b0;
    int         seed = 0;
    logic [7:0] mosi_bytes [0:MAXB-1];
    logic [7:0] rx_buf [0:MAXB-1];
    int rise_cnt, fall_cnt, cs_low, rx_cnt, last_cnt, last_pos, done_cnt, stall;
    logic prev_sck = 1'b0;

    function automatic logic [7:0] slave_byte(input int j, input int s);
        slave_byte = 8'((j * 29 + s * 7 + 3) ^ (j >> 3));
    endfunction

    always @(negedge clk) begin
        logic [7:0] sb;
        if (clr) begin
            rise_cnt = 0; fall_cnt = 0; cs_low = 0; rx_cnt = 0;
            last_cnt = 0; last_pos = -1; done_cnt = 0; stall = 0;
            prev_sck = 1'b0;
            for (int i = 0; i < MAXB; i++) begin
                mosi_bytes[i] = 8'h00;
                rx_buf[i] = 8'h00;
            end
        end else if (!rst) begin
            if (!cs_n) begin
                cs_low++;
                if (cs_low > 1 && sck == prev_sck) stall++;
            end
            if (sck && !prev_sck) begin
                if (rise_cnt / 8 < MAXB)
                    mosi_bytes[rise_cnt/8] = {mosi_bytes[rise_cnt/8][6:0], mosi};
                rise_cnt++;
            end
            if (!sck && prev_sck) fall_cnt++;
            if (rx_valid) begin
                if (rx_cnt < MAXB) rx_buf[rx_cnt] = rx_data;
                if (rx_last) begin
                    last_cnt++;
                    last_pos = rx_cnt;
                end
                rx_cnt++;
            end
            if (done) done_cnt++;
            prev_sck = sck;
        end
        sb = slave_byte(fall_cnt / 8, seed);
        miso = sb[7 - (fall_cnt % 8)];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n, input bit inject);
        int nm1;
        int bad;
        bit seen;
        nm1 = n - 1;
        seed = n + 11;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        req_len = 16'(n);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) begin
            // R9: done the cycle after the request, nothing else moves
            chk(done == 1'b1 && cs_n == 1'b1 && busy == 1'b0, "R9", {29'd0, done, cs_n, busy}, 3'b110);
            repeat (40) @(negedge clk);
            chk(cs_low == 0 && rise_cnt == 0 && rx_cnt == 0, "R9", cs_low + rise_cnt + rx_cnt, 0);
            chk(done_cnt == 1, "R9", done_cnt, 1);
            return;
        end
        // R2: frame opens at once with bit 7 of 0x8C on mosi
        chk(cs_n == 1'b0 && mosi == 1'b1 && sck == 1'b0, "R2", {29'd0, cs_n, mosi, sck}, 3'b010);
        seen = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (inject && k == 40) begin
                chk(busy == 1'b1, "R10", busy, 1);
                req_len = 16'd3;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                seen = 1;
                // R8: frame closed on the completing edge
                chk(cs_n == 1'b1 && sck == 1'b0, "R8", {30'd0, cs_n, sck}, 2'b10);
                break;
            end
        end
        req_valid = 1'b0;
        chk(seen, "R8", seen, 1);
        repeat (4) @(negedge clk);
        // R4
        chk(mosi_bytes[0] == 8'h8C, "R4", mosi_bytes[0], 8'h8C);
        chk(mosi_bytes[1] == 8'(nm1), "R4", mosi_bytes[1], nm1 & 255);
        chk(mosi_bytes[2] == 8'h8D, "R4", mosi_bytes[2], 8'h8D);
        chk(mosi_bytes[3] == 8'(nm1 >> 8), "R4", mosi_bytes[3], (nm1 >> 8) & 255);
        // R5
        chk(mosi_bytes[4] == 8'h00, "R5", mosi_bytes[4], 0);
        chk(rx_cnt == n, "R5", rx_cnt, n);
        // R6
        bad = 0;
        for (int i = 5; i < n + 5; i++) if (mosi_bytes[i] != 8'h00) bad++;
        chk(bad == 0, "R6", bad, 0);
        bad = 0;
        for (int i = 0; i < n; i++) if (rx_buf[i] != slave_byte(i + 5, seed)) bad++;
        chk(bad == 0, "R6", bad, 0);
        // R7
        chk(last_cnt == 1 && last_pos == n - 1, "R7", last_pos, n - 1);
        // R8
        chk(cs_low == 16 * (n + 5), "R8", cs_low, 16 * (n + 5));
        chk(done_cnt == 1, "R8", done_cnt, 1);
        // R3
        chk(rise_cnt == 8 * (n + 5) && stall == 0, "R3", rise_cnt, 8 * (n + 5));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(sck == 0 && cs_n == 1 && mosi == 0, "R1", {29'd0, sck, cs_n, mosi}, 3'b010);
        chk(busy == 0 && done == 0 && rx_valid == 0, "R1", {29'd0, busy, done, rx_valid}, 0);
        run(0, 0);
        run(1, 0);
        run(2, 0);
        run(3, 0);
        run(7, 1);   // R10: mid-frame request must not disturb this frame
        run(255, 0);
        run(256, 0);
        run(257, 0);
        run(300, 0);
        run(0, 0);
        run(5, 0);
        @(negedge clk);
        chk(sck == 0 && cs_n == 1 && mosi == 0 && busy == 0, "R1", {28'd0, sck, cs_n, mosi, busy}, 4'b0100);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule